// File: doc/BRIEF.md
# Handshaked Serial Result Output Port

This block sits between the conversion logic of a measurement front end and an external host. The conversion logic hands it a 16-bit result together with a one-cycle update request. The host reads the word one bit at a time, most significant bit first. It selects the port with an active-low select line and supplies its own serial clock. The serial data pin is modelled as an output enable plus a data bit, so the pad ring builds the high-impedance driver.

An active-low ready flag tells the host when unread data is waiting. An update request does not overwrite the port at once. The flag is first forced high for a fixed lead window of two system clocks. At the end of that window the new word is taken only if the port is empty, or if the host has the port deselected. A word that is being read, with the select held low, is never torn.

Both host inputs are asynchronous. They pass through two-flop synchronizers, and their edges are detected in the system clock domain. The host must therefore keep each serial clock phase several system clocks long.

Top module: `serial_result_port`

## Requirements
- R1: While reset is asserted and right after it, `readyN` is 1, `sdataOe` is 0 and `sdataBit` is 0.
- R2: An `updateReq` pulse sampled on edge k drives `readyN` to 1 after edges k and k+1. The decision is made on edge k+2. If the port is empty, or the synchronized `csN` is 1, `resultIn` (captured on edge k) becomes the port word. `readyN` is 0 after edge k+2 whenever the port then holds a word.
- R3: If the port holds a word and the synchronized `csN` is 0 when the decision is made, the update is dropped. The old word stays readable without any break.
- R4: A falling edge of `csN` while the port holds a word and no lead window is open starts a read. `sdataOe` goes to 1 and `sdataBit` shows bit 15 of the word.
- R5: The first rising `sclk` edge after the read starts arms the shifter and does not change the data. A falling `sclk` edge seen before that rising edge is ignored.
- R6: Once the shifter is armed, each falling `sclk` edge moves `sdataBit` to the next lower bit. The 16 bits come out in the order 15 down to 0.
- R7: The falling `sclk` edge after bit 0 sets `sdataOe` to 0 and empties the port, so `readyN` becomes 1.
- R8: If `csN` rises after the shifter is armed, the current bit stays driven until the next falling `sclk` edge, and then `sdataOe` goes to 0. The partly read word still counts as held (`readyN` 0), and the next update replaces it because `csN` is high.
- R9: A falling edge of `csN` that is detected while the lead window is open is not recognized. No read starts from it, even if a word is loaded at the end of the window.
- R10: `sclk` and `csN` pass through two synchronizer flops plus an edge register. A pin change made between edges shows at the outputs after the third following rising clock edge, and not after the second.
- R11: `sdataBit` is 0 whenever `sdataOe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resultIn | input | 16 | Result word from the conversion logic, captured with `updateReq` |
| updateReq | input | 1 | One-cycle request to publish `resultIn` |
| csN | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdataOe | output | 1 | Serial data output enable (0 means high impedance) |
| sdataBit | output | 1 | Serial data bit |
| readyN | output | 1 | Ready flag, 0 when an unread word is waiting |

## Verification
Host pin changes reach the outputs three rising edges after they are made. One check samples exactly two and three clock periods after a select to pin down that latency. Every other host step waits six clock periods, so the result is sampled after it has settled. The ready flag is checked on the exact cycles after an update pulse: high after the pulse edge and the edge that follows, and low after the decision edge. The select-inside-window case places the select edge so that it is detected on the first cycle of the window.

// File: rtl/sport_pkg.sv
package sport_pkg;
  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic capture;   // latch incoming result into the pending register
    logic load;      // move pending word into the port register
    logic startRd;   // begin a host read at the top bit
    logic advance;   // step to the next lower bit
  } sportStrobe_t;
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int N = 2,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut,
  output logic [N-1:0] riseEv,
  output logic [N-1:0] fallEv
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
      prevQ <= RESET_VAL;
    end else begin
      stg[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prevQ <= stg[STAGES-1];
    end
  end

  assign syncOut = stg[STAGES-1];
  assign riseEv  = syncOut & ~prevQ;
  assign fallEv  = ~syncOut & prevQ;
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int WINDOW = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         updateReq,
  input  logic         csSync,
  input  logic         csFallEv,
  input  logic         csRiseEv,
  input  logic         sclkRiseEv,
  input  logic         sclkFallEv,
  input  logic         lastBit,
  output sportStrobe_t strb,
  output logic         active,
  output logic         winBusy,
  output logic         readyN
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WINDOW);

  logic [CW-1:0] winCnt;
  logic          full;
  logic          armed;
  logic          finishing;
  logic          decide;
  logic          finishRd;
  logic          stopEarly;
  logic          bitFall;

  always_comb begin
    winBusy      = (winCnt != '0);
    decide       = (winCnt == CW'(1));
    bitFall      = active && armed && !finishing && sclkFallEv;
    strb.capture = updateReq && !winBusy;
    strb.load    = decide && (!full || csSync);
    strb.startRd = csFallEv && full && !winBusy && !active && !strb.load;
    strb.advance = bitFall && !lastBit;
    finishRd     = bitFall && lastBit;
    stopEarly    = active && ((csRiseEv && !armed) || (finishing && sclkFallEv));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt    <= '0;
      full      <= 1'b0;
      active    <= 1'b0;
      armed     <= 1'b0;
      finishing <= 1'b0;
    end else begin
      if (strb.capture)  winCnt <= WIN_LOAD;
      else if (winBusy)  winCnt <= winCnt - 1'b1;

      if (strb.load)     full <= 1'b1;
      else if (finishRd) full <= 1'b0;

      if (strb.load)                  active <= 1'b0;
      else if (strb.startRd)          active <= 1'b1;
      else if (finishRd || stopEarly) active <= 1'b0;

      if (strb.load || strb.startRd)   armed <= 1'b0;
      else if (active && sclkRiseEv)   armed <= 1'b1;

      if (strb.load || strb.startRd || finishRd || stopEarly) finishing <= 1'b0;
      else if (active && armed && csRiseEv)                    finishing <= 1'b1;
    end
  end

  assign readyN = winBusy || !full;
endmodule

// File: rtl/sport_datapath.sv
module sport_datapath
  import sport_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sportStrobe_t     strb,
  input  logic             active,
  input  logic [WIDTH-1:0] resultIn,
  output logic             lastBit,
  output logic             sdataBit
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

  logic [WIDTH-1:0] pendWord;
  logic [WIDTH-1:0] portWord;
  logic [IW-1:0]    bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord <= '0;
      portWord <= '0;
      bitIdx   <= TOP_IDX;
    end else begin
      if (strb.capture) pendWord <= resultIn;
      if (strb.load)    portWord <= pendWord;
      if (strb.load || strb.startRd) bitIdx <= TOP_IDX;
      else if (strb.advance)         bitIdx <= bitIdx - 1'b1;
    end
  end

  assign lastBit  = (bitIdx == '0);
  assign sdataBit = active && portWord[bitIdx];
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import sport_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int WINDOW = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] resultIn,
  input  logic             updateReq,
  input  logic             csN,
  input  logic             sclk,
  output logic             sdataOe,
  output logic             sdataBit,
  output logic             readyN
);
  sportStrobe_t strb;
  logic [1:0]   pinSync;
  logic [1:0]   pinRise;
  logic [1:0]   pinFall;
  logic         ctrlActive;
  logic         winBusy;
  logic         lastBit;
  logic         sclkFallEv;

  // bit 1: select line (idles high), bit 0: serial clock (idles low)
  sport_sync #(.N(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b10)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, sclk}),
    .syncOut(pinSync), .riseEv(pinRise), .fallEv(pinFall)
  );

  assign sclkFallEv = pinFall[0];

  sport_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .updateReq(updateReq),
    .csSync(pinSync[1]), .csFallEv(pinFall[1]), .csRiseEv(pinRise[1]),
    .sclkRiseEv(pinRise[0]), .sclkFallEv(sclkFallEv), .lastBit(lastBit),
    .strb(strb), .active(ctrlActive), .winBusy(winBusy), .readyN(readyN)
  );

  sport_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .active(ctrlActive),
    .resultIn(resultIn), .lastBit(lastBit), .sdataBit(sdataBit)
  );

  assign sdataOe = ctrlActive;
endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk (
  input logic clk,
  input logic rstN,
  input logic updateReq,
  input logic winBusy,
  input logic readyN,
  input logic sdataOe,
  input logic sdataBit,
  input logic sclkFallEv
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !sdataOe |-> !sdataBit);  // R11

  AST_LEAD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    updateReq && !winBusy |=> readyN);  // R2

  AST_LEAD_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    updateReq && !winBusy |=> ##1 readyN);  // R2

  AST_READ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> $past(!readyN));  // R4

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    sdataOe && $past(sdataOe) && !$past(sclkFallEv) |-> $stable(sdataBit));  // R6
endmodule

bind serial_result_port serial_result_port_chk u_chk (
  .clk(clk), .rstN(rstN), .updateReq(updateReq), .winBusy(winBusy),
  .readyN(readyN), .sdataOe(sdataOe), .sdataBit(sdataBit),
  .sclkFallEv(sclkFallEv)
);

// File: tb/serial_result_port_tb.sv
module serial_result_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;
  localparam int NVEC = 4;
  // each entry: {stimulus word, expected word read back}
  localparam logic [31:0] VECS [NVEC] = '{
    {16'hA5C3, 16'hA5C3}, {16'h0001, 16'h0001},
    {16'h8000, 16'h8000}, {16'hFFFF, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] resultIn = '0;
  logic        updateReq = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdataOe;
  logic        sdataBit;
  logic        readyN;

  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 0;
  logic [15:0] rdWord;
  int          rdPos;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_result_port u_dut (
    .clk(clk), .rstN(rstN), .resultIn(resultIn), .updateReq(updateReq),
    .csN(csN), .sclk(sclk), .sdataOe(sdataOe), .sdataBit(sdataBit),
    .readyN(readyN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUpdate(input logic [15:0] w);
    @(negedge clk);
    resultIn  = w;
    updateReq = 1'b1;
    @(negedge clk);
    updateReq = 1'b0;
  endtask

  // publish a word and check the lead window cycle by cycle
  task automatic sendUpdate(input logic [15:0] w);
    pulseUpdate(w);
    chk("R2 lead cycle 1", readyN, 1);
    waitClk(1);
    chk("R2 lead cycle 2", readyN, 1);
    waitClk(1);
    chk("R2 held after decision", readyN, 0);
  endtask

  task automatic setSclk(input logic v);
    sclk = v;
    waitClk(SETTLE);
  endtask

  task automatic setCs(input logic v);
    csN = v;
    waitClk(SETTLE);
  endtask

  // sample current bit, then one rise and one fall of the serial clock
  task automatic readBits(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R6 driving during read", sdataOe, 1);
      rdWord[rdPos] = sdataBit;
      rdPos--;
      setSclk(1'b1);
      setSclk(1'b0);
    end
  endtask

  task automatic readWord(input logic [15:0] expWord, input string req);
    rdWord = '0;
    rdPos  = 15;
    setCs(1'b0);
    chk("R4 select drives data", sdataOe, 1);
    readBits(16);
    chk(req, rdWord, expWord);
    chk("R7 off after last bit", sdataOe, 0);
    chk("R7 empty after last bit", readyN, 1);
    chk("R11 quiet when off", sdataBit, 0);
    setCs(1'b1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    waitClk(2);
    chk("R1 reset readyN", readyN, 1);
    chk("R1 reset oe", sdataOe, 0);
    chk("R1 reset bit", sdataBit, 0);
    rstN = 1'b1;
    waitClk(SETTLE);
    chk("R1 after reset readyN", readyN, 1);
    chk("R1 after reset oe", sdataOe, 0);

    // table-driven full transfers (R2, R6, R7)
    for (int v = 0; v < NVEC; v++) begin
      sendUpdate(VECS[v][31:16]);
      readWord(VECS[v][15:0], "R6 word read back");
    end

    // R10: synchronizer latency of a select edge
    sendUpdate(16'h8421);
    @(negedge clk);
    csN = 1'b0;
    waitClk(2);
    chk("R10 no response after two edges", sdataOe, 0);
    waitClk(1);
    chk("R10 response after third edge", sdataOe, 1);
    chk("R4 top bit shown", sdataBit, 1);
    waitClk(SETTLE);
    rdWord = '0;
    rdPos  = 15;
    readBits(16);
    chk("R6 word after latency test", rdWord, 16'h8421);
    setCs(1'b1);

    // R5: fall before arming ignored
    sendUpdate(16'h4000);
    setSclk(1'b1);
    setCs(1'b0);
    chk("R4 top bit of 4000", sdataBit, 0);
    setSclk(1'b0);
    chk("R5 early fall ignored", sdataBit, 0);
    setSclk(1'b1);
    chk("R5 arming rise keeps data", sdataBit, 0);
    setSclk(1'b0);
    chk("R6 first armed fall gives bit 14", sdataBit, 1);
    rdWord = 16'h0000;
    rdPos  = 14;
    readBits(15);
    chk("R6 rest of 4000", rdWord, 16'h4000);
    chk("R7 off after last bit", sdataOe, 0);
    setCs(1'b1);

    // R8: early deselect, then replacement
    sendUpdate(16'hF0F0);
    setCs(1'b0);
    rdWord = '0;
    rdPos  = 15;
    readBits(4);
    setCs(1'b1);
    chk("R8 bit held after deselect", sdataOe, 1);
    chk("R8 held bit value", sdataBit, 0);
    setSclk(1'b1);
    setSclk(1'b0);
    chk("R8 off after next fall", sdataOe, 0);
    chk("R8 word still counts as held", readyN, 0);
    sendUpdate(16'h1234);
    readWord(16'h1234, "R8 replacement word");

    // R3: update while being read is dropped
    sendUpdate(16'hC3A5);
    setCs(1'b0);
    rdWord = '0;
    rdPos  = 15;
    readBits(4);
    sendUpdate(16'h5555);
    readBits(12);
    chk("R3 old word kept", rdWord, 16'hC3A5);
    chk("R3 empty after read", readyN, 1);
    setCs(1'b1);

    // R9: select edge inside the lead window is not recognized
    @(negedge clk);
    csN = 1'b0;
    pulseUpdate(16'h9999);
    waitClk(SETTLE);
    chk("R9 word loaded", readyN, 0);
    chk("R9 no read started", sdataOe, 0);
    chk("R11 quiet when off", sdataBit, 0);
    setCs(1'b1);
    readWord(16'h9999, "R9 word read after reselect");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule